// File: doc/BRIEF.md
# Setup-Frame Perfect Destination Address Filter

This block holds a table of sixteen 48-bit destination addresses and decides, for every received frame, whether the frame is wanted. The table is written through a stream of 32-bit setup words. Each table entry spans three consecutive words, and only the low 16 bits of each word carry address bytes. Forty-eight words make one complete table. The new table is built in a shadow copy. It replaces the table in use only after the forty-eighth word, so filtering never runs against a half-written table.

Received frames arrive one byte per cycle, qualified by a valid strobe, and the first byte of each frame carries a start flag. The filter collects the first six bytes, which are the destination address, and compares them against all sixteen entries in parallel. It then raises a one-cycle accept or reject pulse. A promiscuous input overrides the table and accepts every frame that reaches six bytes. A frame that is cut short by the next start flag before its sixth byte is rejected.

Two state machines run the block. The loader has the states LD_IDLE and LD_FILL. It moves from LD_IDLE to LD_FILL on the first setup word of a table, and from LD_FILL back to LD_IDLE on the forty-eighth word, which also issues the commit pulse. The receive side has the states RX_IDLE, RX_ADDR and RX_SKIP. A start flag moves it from any state to RX_ADDR. The sixth byte moves it from RX_ADDR to RX_SKIP, where the decision is made. In RX_SKIP and RX_IDLE, bytes without a start flag leave the state unchanged.

Top module: `afl_filter`

## Requirements
- R1: Reset clears both outputs and marks the table empty. Until the first complete table has been committed, no frame matches, so only promiscuous mode accepts frames. This holds even for an all-zero destination address.
- R2: Setup word number w (counting from 0, and only words with setup_valid high) fills table entry w/3. Bits 7:0 of the word become address byte 2*(w%3) and bits 15:8 become byte 2*(w%3)+1. Bits 31:16 of every word are ignored.
- R3: The destination byte k (k = 0 being the byte with the start flag) is compared with byte k of each entry. In the cycle after the sixth valid byte is sampled, exactly one of frame_accept and frame_reject pulses high for one cycle. frame_accept pulses when the address equals any entry; otherwise frame_reject pulses.
- R4: With promisc_en high when the sixth byte is sampled, the frame is accepted regardless of the table.
- R5: A start flag that arrives while fewer than six bytes of the current frame have been seen gives a frame_reject pulse in the next cycle, even in promiscuous mode. The byte carrying that flag starts the next frame.
- R6: After a frame's decision, further bytes without a start flag produce no output pulse.
- R7: While a new table is being written, the previous table stays in use. The last setup word is sampled at edge E. A sixth byte sampled at edge E or E+1 uses the old table. A sixth byte sampled at edge E+2 or later uses the new table.
- R8: frame_accept and frame_reject are never high together.
- R9: Cycles with rx_valid low are ignored by the receive side. Cycles with setup_valid low are ignored by the loader.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| setup_word | input | 32 | Setup table word; the low half carries two address bytes |
| setup_valid | input | 1 | Qualifies setup_word |
| rx_byte | input | 8 | Received frame byte |
| rx_valid | input | 1 | Qualifies rx_byte |
| rx_sof | input | 1 | Marks rx_byte as the first byte of a frame |
| promisc_en | input | 1 | Accept every frame that reaches six bytes |
| frame_accept | output | 1 | One-cycle pulse: the frame is wanted |
| frame_reject | output | 1 | One-cycle pulse: the frame is not wanted or is too short |

## Verification
A decision is due one edge after the sixth valid byte, and a short-frame reject is due one edge after the start flag that cuts the frame off. The bench drives every input at the falling edge and reads the outputs just after the rising edge that samples the relevant byte. It also checks the following cycle to confirm that each pulse lasts one cycle. The table swap is checked at both sides of its two-edge boundary: the sixth byte lands one edge after the last setup word, where the old result is expected, and later frames are expected to match the new table.

// File: rtl/afl_pkg.sv
package afl_pkg;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_ADDR,
        RX_SKIP
    } rx_state_t;

    typedef enum logic {
        LD_IDLE,
        LD_FILL
    } ld_state_t;

endpackage

// File: rtl/afl_setup_loader.sv
module afl_setup_loader
    import afl_pkg::*;
#(
    parameter int N_ENT  = 16,
    parameter int WPE    = 3,
    parameter int WORD_W = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [WORD_W-1:0]            setup_word_i,
    input  logic                         setup_valid_i,
    output logic [N_ENT*WPE*WORD_W/2-1:0] shadow_o,
    output logic                         commit_o
);

    localparam int HALF_W = WORD_W / 2;
    localparam int AW     = WPE * HALF_W;
    localparam int ENT_W  = (N_ENT > 1) ? $clog2(N_ENT) : 1;
    localparam int PART_W = (WPE > 1) ? $clog2(WPE) : 1;

    ld_state_t         ld_q, ld_d;
    logic [ENT_W-1:0]  ent_q, ent_d;
    logic [PART_W-1:0] part_q, part_d;
    logic [AW-1:0]     shadow_q [N_ENT];
    logic              commit_q;
    logic              last_word;
    logic              unused_hi;

    // Upper half of every setup word carries no address bytes.
    assign unused_hi = ^setup_word_i[WORD_W-1:HALF_W];

    assign last_word = setup_valid_i
                    && (ent_q == ENT_W'(N_ENT - 1))
                    && (part_q == PART_W'(WPE - 1));

    // Next-state and word-position logic
    always_comb begin
        ld_d   = ld_q;
        ent_d  = ent_q;
        part_d = part_q;
        unique case (ld_q)
            LD_IDLE: begin
                if (setup_valid_i && !last_word) begin
                    ld_d = LD_FILL;
                end
            end
            LD_FILL: begin
                if (last_word) begin
                    ld_d = LD_IDLE;
                end
            end
            default: ld_d = LD_IDLE;
        endcase
        if (setup_valid_i) begin
            if (last_word) begin
                ent_d  = '0;
                part_d = '0;
            end else if (part_q == PART_W'(WPE - 1)) begin
                part_d = '0;
                ent_d  = ent_q + 1'b1;
            end else begin
                part_d = part_q + 1'b1;
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_q   <= LD_IDLE;
            ent_q  <= '0;
            part_q <= '0;
        end else begin
            ld_q   <= ld_d;
            ent_q  <= ent_d;
            part_q <= part_d;
        end
    end

    // Outputs: shadow table contents and commit pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_q <= 1'b0;
            for (int e = 0; e < N_ENT; e++) begin
                shadow_q[e] <= '0;
            end
        end else begin
            commit_q <= last_word;
            if (setup_valid_i) begin
                shadow_q[ent_q][part_q*HALF_W +: HALF_W] <= setup_word_i[HALF_W-1:0];
            end
        end
    end

    assign commit_o = commit_q;

    for (genvar e = 0; e < N_ENT; e++) begin : g_flat
        assign shadow_o[e*AW +: AW] = shadow_q[e];
    end

endmodule

// File: rtl/afl_match_table.sv
module afl_match_table #(
    parameter int N_ENT = 16,
    parameter int AW    = 48
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                commit_i,
    input  logic [N_ENT*AW-1:0] shadow_i,
    input  logic [AW-1:0]       probe_i,
    output logic                hit_o
);

    logic [AW-1:0]    active_q [N_ENT];
    logic             loaded_q;
    logic [N_ENT-1:0] hit_vec;

    // Active table is replaced as a whole on commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loaded_q <= 1'b0;
            for (int e = 0; e < N_ENT; e++) begin
                active_q[e] <= '0;
            end
        end else if (commit_i) begin
            loaded_q <= 1'b1;
            for (int e = 0; e < N_ENT; e++) begin
                active_q[e] <= shadow_i[e*AW +: AW];
            end
        end
    end

    for (genvar e = 0; e < N_ENT; e++) begin : g_cmp
        assign hit_vec[e] = loaded_q && (active_q[e] == probe_i);
    end

    assign hit_o = |hit_vec;

endmodule

// File: rtl/afl_filter.sv
module afl_filter
    import afl_pkg::*;
#(
    parameter int N_ENT      = 16,
    parameter int WPE        = 3,
    parameter int WORD_W     = 32,
    parameter int ADDR_BYTES = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] setup_word,
    input  logic              setup_valid,
    input  logic [7:0]        rx_byte,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic              promisc_en,
    output logic              frame_accept,
    output logic              frame_reject
);

    localparam int HALF_W = WORD_W / 2;
    localparam int AW     = WPE * HALF_W;
    localparam int CNT_W  = $clog2(ADDR_BYTES);
    localparam int LAST   = ADDR_BYTES - 1;

    rx_state_t        rx_q, rx_d;
    logic [CNT_W-1:0] cnt_q;
    logic [7:0]       hold_q [LAST];
    logic [AW-1:0]    probe;
    logic [N_ENT*AW-1:0] shadow;
    logic             commit;
    logic             hit;
    logic             sof_ev, last_ev, short_ev, store_ev;
    logic             accept_q, reject_q;

    afl_setup_loader #(
        .N_ENT (N_ENT),
        .WPE   (WPE),
        .WORD_W(WORD_W)
    ) loader_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .setup_word_i (setup_word),
        .setup_valid_i(setup_valid),
        .shadow_o     (shadow),
        .commit_o     (commit)
    );

    afl_match_table #(
        .N_ENT(N_ENT),
        .AW   (AW)
    ) table_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit_i(commit),
        .shadow_i(shadow),
        .probe_i (probe),
        .hit_o   (hit)
    );

    // Destination address: held bytes plus the live sixth byte
    for (genvar k = 0; k < LAST; k++) begin : g_probe
        assign probe[8*k +: 8] = hold_q[k];
    end
    assign probe[8*LAST +: 8] = rx_byte;

    assign sof_ev   = rx_valid && rx_sof;
    assign last_ev  = rx_valid && !rx_sof && (rx_q == RX_ADDR) && (cnt_q == CNT_W'(LAST));
    assign store_ev = rx_valid && !rx_sof && (rx_q == RX_ADDR) && (cnt_q != CNT_W'(LAST));
    assign short_ev = sof_ev && (rx_q == RX_ADDR);

    // Next-state logic
    always_comb begin
        rx_d = rx_q;
        unique case (rx_q)
            RX_IDLE: if (sof_ev) rx_d = RX_ADDR;
            RX_ADDR: begin
                if (sof_ev) begin
                    rx_d = RX_ADDR;
                end else if (last_ev) begin
                    rx_d = RX_SKIP;
                end
            end
            RX_SKIP: if (sof_ev) rx_d = RX_ADDR;
            default: rx_d = RX_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= RX_IDLE;
        end else begin
            rx_q <= rx_d;
        end
    end

    // Address byte collection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int k = 0; k < LAST; k++) begin
                hold_q[k] <= '0;
            end
        end else if (sof_ev) begin
            hold_q[0] <= rx_byte;
            cnt_q     <= CNT_W'(1);
        end else if (store_ev) begin
            hold_q[cnt_q] <= rx_byte;
            cnt_q         <= cnt_q + 1'b1;
        end
    end

    // Decision outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept_q <= 1'b0;
            reject_q <= 1'b0;
        end else begin
            accept_q <= last_ev && (promisc_en || hit);
            reject_q <= short_ev || (last_ev && !promisc_en && !hit);
        end
    end

    assign frame_accept = accept_q;
    assign frame_reject = reject_q;

endmodule

// File: rtl/afl_checker.sv
module afl_checker
    import afl_pkg::*;
#(
    parameter int CNT_W = 3,
    parameter int LAST  = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_valid,
    input logic             rx_sof,
    input logic             promisc_en,
    input logic             frame_accept,
    input logic             frame_reject,
    input logic             commit,
    input rx_state_t        rx_state,
    input logic [CNT_W-1:0] byte_cnt
);

    logic seen_commit;
    logic decide;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_commit <= 1'b0;
        end else if (commit) begin
            seen_commit <= 1'b1;
        end
    end

    assign decide = rx_valid && !rx_sof && (rx_state == RX_ADDR)
                 && (byte_cnt == CNT_W'(LAST));

    // R8
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_accept && frame_reject));

    // R4
    a_r4_promisc_accept: assert property (@(posedge clk) disable iff (!rst_n)
        decide && promisc_en |=> frame_accept);

    // R1
    a_r1_empty_reject: assert property (@(posedge clk) disable iff (!rst_n)
        decide && !promisc_en && !seen_commit |=> frame_reject);

    // R5
    a_r5_short_reject: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_sof && (rx_state == RX_ADDR) |=> frame_reject && !frame_accept);

    // R6
    a_r6_quiet_after: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_state != RX_ADDR) |=> !frame_accept && !frame_reject);

    // R9
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> !frame_accept && !frame_reject);

endmodule

bind afl_filter afl_checker #(
    .CNT_W(CNT_W),
    .LAST (LAST)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_valid    (rx_valid),
    .rx_sof      (rx_sof),
    .promisc_en  (promisc_en),
    .frame_accept(frame_accept),
    .frame_reject(frame_reject),
    .commit      (commit),
    .rx_state    (rx_q),
    .byte_cnt    (cnt_q)
);

// File: tb/afl_filter_tb_top.sv
module afl_filter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] setup_word;
    logic        setup_valid;
    logic [7:0]  rx_byte;
    logic        rx_valid;
    logic        rx_sof;
    logic        promisc_en;
    logic        frame_accept;
    logic        frame_reject;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    localparam logic [15:0] JUNK = 16'hA5C3;

    logic [47:0] tbl_a [16];
    logic [47:0] tbl_b [16];

    always #4 clk = ~clk;

    afl_filter dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .setup_word  (setup_word),
        .setup_valid (setup_valid),
        .rx_byte     (rx_byte),
        .rx_valid    (rx_valid),
        .rx_sof      (rx_sof),
        .promisc_en  (promisc_en),
        .frame_accept(frame_accept),
        .frame_reject(frame_reject)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic step(input logic cv, input logic [31:0] w, input logic rv,
                        input logic sof, input logic [7:0] b);
        @(negedge clk);
        setup_valid = cv;
        setup_word  = w;
        rx_valid    = rv;
        rx_sof      = sof;
        rx_byte     = b;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        step(1'b0, 32'h0BAD_F00D, 1'b0, 1'b0, 8'h5A);
    endtask

    task automatic check_quiet(input string req);
        check(req, "accept quiet", frame_accept, 1'b0);
        check(req, "reject quiet", frame_reject, 1'b0);
    endtask

    function automatic logic [31:0] word_of(input logic [47:0] a, input int part);
        return {JUNK, a[16*part +: 16]};
    endfunction

    task automatic load_words(input bit use_b, input int from, input int upto, input bit gaps);
        for (int w = from; w <= upto; w++) begin
            logic [47:0] a;
            a = use_b ? tbl_b[w/3] : tbl_a[w/3];
            step(1'b1, word_of(a, w % 3), 1'b0, 1'b0, 8'h00);
            if (gaps) step(1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0, 8'h00);
        end
    endtask

    // Full six-byte frame; decision checked one edge after the sixth byte
    task automatic send_addr(input logic [47:0] a, input logic exp_acc, input string req);
        for (int k = 0; k < 6; k++) begin
            step(1'b0, 32'h0, 1'b1, (k == 0), a[8*k +: 8]);
        end
        check(req, "accept", frame_accept, exp_acc);
        check(req, "reject", frame_reject, !exp_acc);
        idle();
        check_quiet("R3 pulse width");
    endtask

    task automatic t_empty();
        send_addr(48'h0, 1'b0, "R1 zero address before load");
        send_addr(tbl_a[3], 1'b0, "R1 table entry before load");
    endtask

    task automatic t_promisc_empty();
        promisc_en = 1'b1;
        send_addr(48'h1234_5678_9ABC, 1'b1, "R4 promiscuous with empty table");
        promisc_en = 1'b0;
    endtask

    task automatic t_match();
        send_addr(tbl_a[0], 1'b1, "R3 broadcast entry 0");
        send_addr(tbl_a[1], 1'b1, "R3 entry 1");
        send_addr(tbl_a[7], 1'b1, "R3 entry 7");
        send_addr(tbl_a[15], 1'b1, "R3 entry 15");
        send_addr({8'h40, 8'h33, 8'h22, 8'h11, 8'h00, 8'h02}, 1'b0, "R3 unknown last byte");
        send_addr({8'h05, 8'h33, 8'h22, 8'h11, 8'h00, 8'h03}, 1'b0, "R3 first byte differs");
        send_addr({JUNK, JUNK, JUNK}, 1'b0, "R2 upper halves ignored");
    endtask

    task automatic t_short();
        step(1'b0, 32'h0, 1'b1, 1'b1, 8'h02);
        step(1'b0, 32'h0, 1'b1, 1'b0, 8'h00);
        step(1'b0, 32'h0, 1'b1, 1'b0, 8'h11);
        check_quiet("R5 before cut");
        step(1'b0, 32'h0, 1'b1, 1'b1, tbl_a[9][7:0]);
        check("R5", "short reject", frame_reject, 1'b1);
        check("R5", "short no accept", frame_accept, 1'b0);
        for (int k = 1; k < 6; k++) begin
            step(1'b0, 32'h0, 1'b1, 1'b0, tbl_a[9][8*k +: 8]);
        end
        check("R5", "restarted frame accept", frame_accept, 1'b1);
        idle();
    endtask

    task automatic t_tail();
        send_addr(tbl_a[2], 1'b1, "R6 lead frame");
        for (int k = 0; k < 6; k++) begin
            step(1'b0, 32'h0, 1'b1, 1'b0, tbl_a[2][8*k +: 8]);
            check_quiet("R6 tail byte");
        end
    endtask

    task automatic t_gaps();
        for (int k = 0; k < 6; k++) begin
            step(1'b0, 32'h0, 1'b1, (k == 0), tbl_a[12][8*k +: 8]);
            if (k < 5) begin
                step(1'b0, 32'h0, 1'b0, 1'b1, 8'hEE);
                check_quiet("R9 gap");
            end
        end
        check("R9", "gapped frame accept", frame_accept, 1'b1);
        idle();
    endtask

    task automatic t_promisc_short();
        promisc_en = 1'b1;
        step(1'b0, 32'h0, 1'b1, 1'b1, 8'h77);
        step(1'b0, 32'h0, 1'b1, 1'b0, 8'h78);
        step(1'b0, 32'h0, 1'b1, 1'b1, 8'h01);
        check("R5", "short reject in promiscuous", frame_reject, 1'b1);
        for (int k = 1; k < 6; k++) begin
            step(1'b0, 32'h0, 1'b1, 1'b0, 8'h90 + 8'(k));
        end
        check("R4", "unknown accepted in promiscuous", frame_accept, 1'b1);
        idle();
        promisc_en = 1'b0;
    endtask

    task automatic t_swap();
        load_words(1'b1, 0, 23, 1'b1);
        send_addr(tbl_a[5], 1'b1, "R7 old table during load");
        send_addr(tbl_b[5], 1'b0, "R7 new table not yet used");
        load_words(1'b1, 24, 46, 1'b1);
        for (int k = 0; k < 5; k++) begin
            step(1'b0, 32'h0, 1'b1, (k == 0), tbl_a[5][8*k +: 8]);
        end
        step(1'b1, word_of(tbl_b[15], 2), 1'b0, 1'b0, 8'h00);
        step(1'b0, 32'h0, 1'b1, 1'b0, tbl_a[5][47:40]);
        check("R7", "old table one edge after last word", frame_accept, 1'b1);
        idle();
        send_addr(tbl_b[5], 1'b1, "R7 new table after swap");
        send_addr(tbl_b[15], 1'b1, "R7 new last entry");
        send_addr(tbl_a[5], 1'b0, "R7 old entry gone");
        send_addr(tbl_b[0], 1'b1, "R7 broadcast kept");
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            tbl_a[i] = (i == 0) ? 48'hFFFF_FFFF_FFFF
                                : {8'(i), 8'h33, 8'h22, 8'h11, 8'h00, 8'h02};
            tbl_b[i] = (i == 0) ? 48'hFFFF_FFFF_FFFF
                                : {8'(i), 8'h77, 8'h66, 8'h55, 8'h44, 8'h0A};
        end
        rst_n       = 1'b0;
        setup_word  = '0;
        setup_valid = 1'b0;
        rx_byte     = '0;
        rx_valid    = 1'b0;
        rx_sof      = 1'b0;
        promisc_en  = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check_quiet("R1 reset");
        @(negedge clk);
        rst_n = 1'b1;
        idle();
        check_quiet("R1 after reset");

        t_empty();
        t_promisc_empty();
        load_words(1'b0, 0, 47, 1'b0);
        idle();
        idle();
        t_match();
        t_short();
        t_tail();
        t_gaps();
        t_promisc_short();
        t_swap();

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog expired actual running expected done");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule